// File: doc/BRIEF.md
# Packed Halfword Averager with Selectable Rounding

This unit takes two 32-bit words, treats each as a pair of signed 16-bit lanes, and produces for every lane the mean of the two lane values, packed back into one 32-bit word. Each lane adds its two operands into a 17-bit sum and halves it with an arithmetic right shift. On its own, that halving rounds toward negative infinity.

When the sum is odd, the halved value may be nudged up by one. Three inputs decide this:

- A core-variant select turns rounding on or off. When it is off, the floored value is always used.
- When rounding is on, a mode-style select chooses between a four-way rounding field and a single legacy round-up bit.
- The rounding field and the round-up bit then give the direction.

The result is captured in an output register together with a valid flag, one cycle after the operands are presented. A parameter can remove that register.

Top module: `halfword_avg`

## Requirements
- R1: When `variant_rounds` is 0, each 16-bit lane of `result` equals floor((a+b)/2) of the signed lane operands, whatever the other rounding inputs are.
- R2: When a lane's 17-bit sum is even, that lane's result is exactly (a+b)/2 in every rounding configuration.
- R3: With `variant_rounds`=1 and `rnd_new_en`=1, `rnd_mode`=0 selects round-to-nearest. An odd sum whose floored half is non-negative (sign bit 0) is incremented by one. An odd sum whose floored half is negative is left floored.
- R4: With `variant_rounds`=1, `rnd_new_en`=1 and `rnd_mode`=1 (toward zero), an odd sum is incremented only when the floored half is negative.
- R5: With `variant_rounds`=1 and `rnd_new_en`=1, `rnd_mode`=2 increments every odd sum (toward positive infinity), and `rnd_mode`=3 leaves every odd sum floored (toward negative infinity).
- R6: With `variant_rounds`=1 and `rnd_new_en`=0, `rnd_mode` has no effect. In this case `legacy_up`=1 increments every odd sum and `legacy_up`=0 leaves it floored.
- R7: The lanes are computed independently. Bits [15:0] come from operand bits [15:0], and bits [31:16] come from operand bits [31:16]. Each lane result is truncated to 16 bits, with no carry into the other lane.
- R8: `result` and `out_valid` are registered. `out_valid` in a cycle equals `in_valid` from the previous cycle, and `result` then holds that cycle's average. Reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 32 | First packed operand, two signed 16-bit lanes |
| op_b | input | 32 | Second packed operand, two signed 16-bit lanes |
| rnd_new_en | input | 1 | 1: use the two-bit rounding field; 0: use the legacy bit |
| rnd_mode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| legacy_up | input | 1 | Legacy control: 1 rounds odd sums up, 0 floors them |
| variant_rounds | input | 1 | 1: core variant supports rounding; 0: always floor |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Packed lane averages |

## Verification
Any error in this block shows up at the ports one cycle after the operands are presented. There is no hidden state apart from the output register, so a wrong sum, a wrong increment decision or a lane crossover appears as a wrong `result` word on the very next valid cycle.

Because the rounding decision depends on the sign of the floored half, the vectors pair positive and negative odd sums in the two lanes at the same time, so that one word exposes a sign-test error. The vectors also include the extreme lane values, where a carry into the neighbouring lane would show.

// File: rtl/halfword_avg.sv
module halfword_avg #(
  parameter int LANE_W  = 16,
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [LANE_W*LANES-1:0]   op_a,
  input  logic [LANE_W*LANES-1:0]   op_b,
  input  logic                      rnd_new_en,
  input  logic [1:0]                rnd_mode,
  input  logic                      legacy_up,
  input  logic                      variant_rounds,
  output logic                      out_valid,
  output logic [LANE_W*LANES-1:0]   result
);
  localparam int W = LANE_W * LANES;

  logic [W-1:0] avg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a, b, half;
    logic [LANE_W:0]   sum;
    logic              bump, dir_up;

    assign a    = op_a[g*LANE_W +: LANE_W];
    assign b    = op_b[g*LANE_W +: LANE_W];
    assign sum  = {a[LANE_W-1], a} + {b[LANE_W-1], b};
    assign half = sum[LANE_W:1];

    always_comb begin
      case (rnd_mode)
        2'd0:    dir_up = ~half[LANE_W-1];
        2'd1:    dir_up =  half[LANE_W-1];
        2'd2:    dir_up = 1'b1;
        default: dir_up = 1'b0;
      endcase
    end

    assign bump = variant_rounds & sum[0] & (rnd_new_en ? dir_up : legacy_up);
    assign avg[g*LANE_W +: LANE_W] = half + {{(LANE_W-1){1'b0}}, bump};
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        result    <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) result <= avg;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = avg;
  end
endmodule

// File: rtl/halfword_avg_chk.sv
module halfword_avg_chk #(
  parameter int LANE_W  = 16,
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [LANE_W*LANES-1:0] op_a,
  input logic [LANE_W*LANES-1:0] op_b,
  input logic                    rnd_new_en,
  input logic [1:0]              rnd_mode,
  input logic                    legacy_up,
  input logic                    variant_rounds,
  input logic                    out_valid,
  input logic [LANE_W*LANES-1:0] result
);
  if (REG_OUT) begin : g_on
    logic       new_q, up_q, var_q;
    logic [1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        new_q <= 1'b0; up_q <= 1'b0; var_q <= 1'b0; mode_q <= 2'd0;
      end else if (in_valid) begin
        new_q <= rnd_new_en; up_q <= legacy_up;
        var_q <= variant_rounds; mode_q <= rnd_mode;
      end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

    for (genvar g = 0; g < LANES; g++) begin : g_l
      logic [LANE_W:0]   sum_q, twice;
      logic [LANE_W-1:0] ra, rb;
      logic              odd, floor_ok, ceil_ok;

      assign ra = op_a[g*LANE_W +: LANE_W];
      assign rb = op_b[g*LANE_W +: LANE_W];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else if (in_valid) sum_q <= {ra[LANE_W-1], ra} + {rb[LANE_W-1], rb};
      end
      assign twice    = {result[g*LANE_W +: LANE_W], 1'b0};
      assign odd      = sum_q[0];
      assign floor_ok = (twice + {{LANE_W{1'b0}}, odd}) == sum_q;
      assign ceil_ok  = twice == (sum_q + {{LANE_W{1'b0}}, odd});

      // R1
      floor_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !var_q |-> floor_ok);
      // R2
      even_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !odd |-> twice == sum_q);
      // R3
      nearest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && var_q && new_q && mode_q == 2'd0 |->
          (sum_q[LANE_W] ? floor_ok : ceil_ok));
      // R4
      to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && var_q && new_q && mode_q == 2'd1 |->
          (sum_q[LANE_W] ? ceil_ok : floor_ok));
      // R5
      to_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && var_q && new_q && mode_q == 2'd2 |-> ceil_ok);
      // R5
      to_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && var_q && new_q && mode_q == 2'd3 |-> floor_ok);
      // R6
      legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && var_q && !new_q |-> (up_q ? ceil_ok : floor_ok));
    end
  end
endmodule

bind halfword_avg halfword_avg_chk #(.LANE_W(LANE_W), .LANES(LANES), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/test_halfword_avg.sv
module test_halfword_avg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        rnd_new_en = 1'b0, legacy_up = 1'b0, variant_rounds = 1'b0;
  logic [1:0]  rnd_mode = 2'd0;
  logic        out_valid;
  logic [31:0] result;

  typedef struct { logic [31:0] exp; string req; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  halfword_avg i_halfword_avg (.*);

  function automatic logic [15:0] lane_model(input logic [15:0] a, input logic [15:0] b,
      input logic ne, input logic [1:0] m, input logic up, input logic v);
    int s, fl, inc;
    s   = int'($signed(a)) + int'($signed(b));
    fl  = s >>> 1;
    inc = 0;
    if (v && (s % 2 != 0)) begin
      if (!ne) inc = up ? 1 : 0;
      else case (m)
        2'd0: inc = (fl >= 0) ? 1 : 0;
        2'd1: inc = (fl < 0) ? 1 : 0;
        2'd2: inc = 1;
        default: inc = 0;
      endcase
    end
    lane_model = 16'(fl + inc);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic ne,
      input logic [1:0] m, input logic up, input logic v, input string req);
    item_t it;
    it.exp = {lane_model(a[31:16], b[31:16], ne, m, up, v),
              lane_model(a[15:0], b[15:0], ne, m, up, v)};
    it.req = req;
    sb.push_back(it);
    op_a = a; op_b = b; rnd_new_en = ne; rnd_mode = m;
    legacy_up = up; variant_rounds = v; in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678;
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (sb.size() == 0) check("R8 unexpected valid", {31'b0, out_valid}, 32'h0);
        else begin
          item_t it;
          it = sb.pop_front();
          check(it.req, result, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    in_valid = 1'b1; op_a = 32'h0003_0003;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {31'b0, out_valid}, 32'h0);
    check("R8 reset result", result, 32'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: variant without rounding always floors
    send(32'hFFFD_0003, 32'h0, 1'b1, 2'd2, 1'b1, 1'b0, "R1 floor");
    send(32'h0005_FFF9, 32'h0002_0000, 1'b0, 2'd0, 1'b1, 1'b0, "R1 floor mixed");
    // R2: even sums exact
    send(32'h0004_FFFA, 32'h0002_0000, 1'b1, 2'd2, 1'b0, 1'b1, "R2 even");
    send(32'h0004_FFFA, 32'h0002_0000, 1'b0, 2'd0, 1'b1, 1'b1, "R2 even legacy");
    // R3: nearest
    send(32'hFFFD_0003, 32'h0, 1'b1, 2'd0, 1'b0, 1'b1, "R3 nearest");
    send(32'hFFFF_0001, 32'h0, 1'b1, 2'd0, 1'b0, 1'b1, "R3 nearest small");
    // R4: toward zero
    send(32'hFFFD_0003, 32'h0, 1'b1, 2'd1, 1'b0, 1'b1, "R4 toward zero");
    send(32'hFFFF_0001, 32'h0, 1'b1, 2'd1, 1'b0, 1'b1, "R4 toward zero small");
    // R5: toward +inf / -inf
    send(32'hFFFD_0003, 32'h0, 1'b1, 2'd2, 1'b0, 1'b1, "R5 toward +inf");
    send(32'hFFFD_0003, 32'h0, 1'b1, 2'd3, 1'b1, 1'b1, "R5 toward -inf");
    // R6: legacy bit, field ignored
    send(32'hFFFD_0003, 32'h0, 1'b0, 2'd3, 1'b1, 1'b1, "R6 legacy up");
    send(32'hFFFD_0003, 32'h0, 1'b0, 2'd2, 1'b0, 1'b1, "R6 legacy floor");
    // R7: extremes and lane independence
    send(32'h7FFF_8000, 32'h7FFE_8000, 1'b1, 2'd2, 1'b0, 1'b1, "R7 extremes");
    send(32'h7FFF_7FFF, 32'h7FFF_7FFE, 1'b1, 2'd0, 1'b0, 1'b1, "R7 no carry");
    send(32'h0000_0001, 32'h0, 1'b1, 2'd2, 1'b0, 1'b1, "R7 low lane only");
    send(32'h0001_0000, 32'h0, 1'b1, 2'd2, 1'b0, 1'b1, "R7 high lane only");
    idle(3);
    check("R8 idle valid low", {31'b0, out_valid}, 32'h0);
    check("R8 result held", result, 32'h0001_0000);

    // R8 + all modes: streamed vectors
    for (int i = 0; i < 60; i++) begin
      logic [31:0] ra, rb, rc;
      ra = $urandom; rb = $urandom; rc = $urandom;
      send(ra, rb, rc[0], rc[2:1], rc[3], rc[4] | rc[5], "R8 stream");
      if (rc[7:6] == 2'b00) idle(1);
    end
    idle(4);
    check("R8 queue drained", 32'(sb.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule